// File: doc/BRIEF.md
# Conflict-Partitioned Guarded-Operation Arbiter

This block decides, every cycle, which of a set of guarded atomic operations may commit. Each operation raises a guard when its precondition holds; the arbiter answers with a fire vector. A compile-time conflict matrix says which pairs of operations must never commit in the same cycle. Any set the arbiter fires is pairwise conflict-free, so the result matches some one-at-a-time ordering of the fired operations. The set is also maximal: an enabled operation is left out only when a fired operation conflicts with it.

At elaboration the arbiter splits the operations into independent groups, the connected components of the conflict graph. Each group has its own scan. When a group has no rotating pointer, the lower index wins. When it has one, the pointer moves past the first winner so that an operation kept enabled cannot starve.

One shared register may be written by several operations. The block produces that register's latch enable and next value. When several writers fire together, the writer with the highest index, which is the latest in the sequential order, supplies the value.

Top module: `guarded_rule_arbiter`

## Requirements
- R1: `fire[i]` is never high while `guard[i]` is low.
- R2: Two operations whose conflict bit `CONFLICT[i*N+j]` is set never fire in the same cycle.
- R3: An operation whose guard is high and that is not fired always has a conflicting operation that is fired in that cycle (maximal set).
- R4: Operations in different connected components of the conflict graph are arbitrated independently: one group's fire bits do not depend on the guards of another group.
- R5: With `ROUND_ROBIN` = 0, each group scans from index 0 upward and takes every enabled operation that does not conflict with one already taken, so lower indices win ties every cycle.
- R6: With `ROUND_ROBIN` = 1, each group's scan starts at index 0 after reset. After any cycle in which the group has an enabled operation, the scan start moves to one past the first operation that fired. An operation held enabled therefore fires within N cycles.
- R7: `reg_we` is high exactly when at least one operation with its `WRITERS` bit set fires.
- R8: `reg_d` equals `next_val[i*W +: W]` of the highest-index firing writer, and is 0 when `reg_we` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the rotating scan pointers |
| rst_n | input | 1 | Active-low synchronous reset |
| guard | input | N | Bit i high when operation i is enabled |
| next_val | input | N*W | Operation i's proposed register value in bits [i*W +: W] |
| fire | output | N | Bit i high when operation i commits this cycle |
| reg_we | output | 1 | Latch enable for the shared register |
| reg_d | output | W | Next value for the shared register |

## Verification
Two things can happen in the same cycle: several writers of the shared register can fire together, and operations in separate groups can win together. Guard patterns with all inputs high, or with writers from two groups high, produce both cases. The bench then compares the register value with the highest-index fired writer and each group's fire bits with that group's own scan. Every one of the 64 guard patterns is also applied under round-robin and judged for safety and maximality, whatever the pointer state is at that moment.

// File: rtl/guarded_rule_arbiter.sv
module guarded_rule_arbiter #(
  parameter int N = 6,
  parameter int W = 8,
  parameter logic [N*N-1:0] CONFLICT = 36'h0_0840_2142,
  parameter logic [N-1:0] WRITERS = 6'b101101,
  parameter bit ROUND_ROBIN = 1'b1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   guard,
  input  logic [N*W-1:0] next_val,
  output logic [N-1:0]   fire,
  output logic           reg_we,
  output logic [W-1:0]   reg_d
);

  localparam int PW = (N > 1) ? $clog2(N) : 1;

  function automatic logic [N*N-1:0] reach_of(input logic [N*N-1:0] c);
    logic [N*N-1:0] r;
    r = c;
    for (int i = 0; i < N; i++) r[i*N+i] = 1'b1;
    for (int k = 0; k < N; k++)
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (r[i*N+k] && r[k*N+j]) r[i*N+j] = 1'b1;
    return r;
  endfunction

  localparam logic [N*N-1:0] REACH = reach_of(CONFLICT);

  function automatic logic [N-1:0] members_of(input int g);
    logic [N-1:0] m;
    m = '0;
    for (int i = 0; i < N; i++) begin
      int lead;
      lead = -1;
      for (int j = N - 1; j >= 0; j--)
        if (REACH[i*N+j]) lead = j;
      if (lead == g) m[i] = 1'b1;
    end
    return m;
  endfunction

  logic [N-1:0][N-1:0] grp_sel;

  for (genvar g = 0; g < N; g++) begin : grp
    localparam logic [N-1:0] MEM = members_of(g);
    if (MEM != '0) begin : live
      logic [PW-1:0] ptr;
      logic [PW-1:0] ptr_nxt;
      logic [N-1:0]  sel;

      always_comb begin
        sel = '0;
        ptr_nxt = ptr;
        for (int k = 0; k < N; k++) begin
          int idx;
          idx = (int'(ptr) + k) % N;
          if (MEM[idx] && guard[idx] && ((sel & CONFLICT[idx*N +: N]) == '0)) begin
            if (sel == '0) ptr_nxt = PW'((idx + 1) % N);
            sel[idx] = 1'b1;
          end
        end
      end

      if (ROUND_ROBIN) begin : rr
        always_ff @(posedge clk) begin
          if (!rst_n) ptr <= '0;
          else if ((guard & MEM) != '0) ptr <= ptr_nxt;
        end
      end else begin : fixed
        assign ptr = '0;
      end

      assign grp_sel[g] = sel;
    end else begin : empty
      assign grp_sel[g] = '0;
    end
  end

  always_comb begin
    fire = '0;
    for (int g = 0; g < N; g++) fire = fire | grp_sel[g];
  end

  assign reg_we = (fire & WRITERS) != '0;

  always_comb begin
    reg_d = '0;
    for (int i = 0; i < N; i++)
      if (WRITERS[i] && fire[i]) reg_d = next_val[i*W +: W];
  end

  // R1
  guard_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire & ~guard) == '0);

  for (genvar i = 0; i < N; i++) begin : pair_a
    for (genvar j = i + 1; j < N; j++) begin : pair_b
      if (CONFLICT[i*N+j]) begin : edge_c
        // R2
        conflict_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
          !(fire[i] && fire[j]));
      end
    end

    // R3
    maximal_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (guard[i] && !fire[i]) |-> ((fire & CONFLICT[i*N +: N]) != '0));

    if (ROUND_ROBIN) begin : fair
      logic [PW:0] wait_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) wait_cnt <= '0;
        else if (guard[i] && !fire[i])
          wait_cnt <= (wait_cnt == (PW+1)'(N)) ? wait_cnt : wait_cnt + 1'b1;
        else wait_cnt <= '0;
      end
      // R6
      fair_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wait_cnt < (PW+1)'(N));
    end
  end

  // R8
  idle_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |-> (reg_d == '0));

endmodule

// File: tb/guarded_rule_arbiter_tb.sv
`timescale 1ns/1ps
module guarded_rule_arbiter_tb_top;
  localparam int N = 6;
  localparam int W = 8;
  localparam logic [N*N-1:0] CM = 36'h0_0840_2142;
  localparam logic [N-1:0] WR = 6'b101101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] g_rr = '0, g_fp = '0;
  logic [N*W-1:0] nv = 48'hA5A4A3A2A1A0;
  logic [N-1:0] f_rr, f_fp;
  logic we_rr, we_fp;
  logic [W-1:0] d_rr, d_fp;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  guarded_rule_arbiter #(.N(N), .W(W), .CONFLICT(CM), .WRITERS(WR), .ROUND_ROBIN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .guard(g_rr), .next_val(nv),
    .fire(f_rr), .reg_we(we_rr), .reg_d(d_rr));

  guarded_rule_arbiter #(.N(N), .W(W), .CONFLICT(CM), .WRITERS(WR), .ROUND_ROBIN(1'b0)) dut_fp_i (
    .clk(clk), .rst_n(rst_n), .guard(g_fp), .next_val(nv),
    .fire(f_fp), .reg_we(we_fp), .reg_d(d_fp));

  // {guard, expected fire, expected reg_we, expected reg_d} for fixed priority
  localparam logic [20:0] VEC [12] = '{
    {6'b000000, 6'b000000, 1'b0, 8'h00},
    {6'b000111, 6'b000101, 1'b1, 8'hA2},
    {6'b000010, 6'b000010, 1'b0, 8'h00},
    {6'b000110, 6'b000010, 1'b0, 8'h00},
    {6'b011000, 6'b001000, 1'b1, 8'hA3},
    {6'b010000, 6'b010000, 1'b0, 8'h00},
    {6'b111111, 6'b101101, 1'b1, 8'hA5},
    {6'b001101, 6'b001101, 1'b1, 8'hA3},
    {6'b100010, 6'b100010, 1'b1, 8'hA5},
    {6'b000100, 6'b000100, 1'b1, 8'hA2},
    {6'b010011, 6'b010001, 1'b1, 8'hA0},
    {6'b110110, 6'b110010, 1'b1, 8'hA5}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] model_d(input logic [N-1:0] f);
    logic [W-1:0] d;
    d = '0;
    for (int i = 0; i < N; i++) if (WR[i] && f[i]) d = nv[i*W +: W];
    return d;
  endfunction

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] seen;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state: nothing fires with no guards; R6 scan starts at index 0
    #1 chk("R1 reset idle fire", 32'(f_rr), 32'h0);
    chk("R7 reset idle we", 32'(we_rr), 32'h0);
    @(negedge clk) g_rr = 6'b000011;
    #1 chk("R6 after reset lowest index first", 32'(f_rr), 32'h01);

    // fixed-priority table (R4 R5 R7 R8)
    for (int v = 0; v < 12; v++) begin
      @(negedge clk) g_fp = VEC[v][20:15];
      #1;
      chk("R5 R4 table fire", 32'(f_fp), 32'(VEC[v][14:9]));
      chk("R7 table we", 32'(we_fp), 32'(VEC[v][8]));
      chk("R8 table d", 32'(d_fp), 32'(VEC[v][7:0]));
    end

    // R5 fixed priority starves op1 while op0 holds
    seen = '0;
    for (int c = 0; c < N; c++) begin
      @(negedge clk) g_fp = 6'b000011;
      #1 seen = seen | f_fp;
    end
    chk("R5 fixed priority keeps op1 out", 32'(seen), 32'h01);

    // exhaustive guard patterns under round robin
    for (int p = 0; p < 64; p++) begin
      logic [N-1:0] f;
      logic bad, miss;
      @(negedge clk) g_rr = 6'(p);
      #1 f = f_rr;
      bad = 1'b0;
      miss = 1'b0;
      for (int i = 0; i < N; i++) begin
        for (int j = 0; j < N; j++)
          if (i != j && CM[i*N+j] && f[i] && f[j]) bad = 1'b1;
        if (g_rr[i] && !f[i] && ((f & CM[i*N +: N]) == '0)) miss = 1'b1;
      end
      chk("R1 fire within guard", 32'(f & ~g_rr), 32'h0);
      chk("R2 no conflicting pair", 32'(bad), 32'h0);
      chk("R3 maximal set", 32'(miss), 32'h0);
      chk("R7 latch enable", 32'(we_rr), 32'((f & WR) != '0));
      chk("R8 last writer value", 32'(d_rr), 32'(model_d(f)));
    end

    // R6 every op fires within N cycles when all are held enabled
    seen = '0;
    for (int c = 0; c < N; c++) begin
      @(negedge clk) g_rr = 6'b111111;
      #1 seen = seen | f_rr;
    end
    chk("R6 all held ops fired within N", 32'(seen), 32'h3F);

    // R6 two mutually conflicting ops alternate
    seen = '0;
    for (int c = 0; c < N; c++) begin
      @(negedge clk) g_rr = 6'b000011;
      #1 seen = seen | f_rr;
    end
    chk("R6 op1 not starved", 32'(seen), 32'h03);

    @(negedge clk) g_rr = '0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule